// File: doc/BRIEF.md
# Conversion Start Sequencer for a Multichannel Sampling Converter

This block times the track/hold and conversion phases of a multichannel successive-approximation converter. A conversion can be started by an edge on an external convert-start pin or by a start bit in a control-register write. The same write selects the input channel and a power-down bit. The comparator and DAC are not modelled. The finished code enters on a behavioural result input and is captured at the end of the conversion window.

When a write changes the selected channel, the block runs a settling pulse of a programmable number of clock cycles. This gives the multiplexer and any external filter time to settle. A start request that arrives during that pulse is not dropped. It is held back, and hold begins automatically once the pulse expires. The convert-start pin is synchronised and width-filtered before it can start anything. Power-down blocks all starts and aborts any conversion that is running.

Top module: `adc_start_seq`

## Requirements
- R1: After reset, hold_o, busy_o, done_o and settling_o are low, the result outputs are zero and the selected channel is 0.
- R2: A convert-start pulse that is sampled high on at least MIN_HI consecutive clock edges after being low starts a conversion. If the block is idle and not settling, busy_o and hold_o rise on the edge MIN_HI+1 edges after the first high sample. A shorter pulse starts nothing.
- R3: A control write with start set, power-down clear and the channel unchanged raises busy_o and hold_o on the write edge itself.
- R4: A control write that changes the channel loads the settling pulse from settle_len_i. settling_o is then high for exactly that many cycles after the write edge. A length of 0 gives no pulse.
- R5: A start request made while settling_o is high, or in the same write that changes the channel, is deferred. The conversion starts on the edge settle_len_i+1 edges after the channel-change write edge.
- R6: busy_o is high for exactly CONV_CYC cycles per conversion, and hold_o equals busy_o at all times.
- R7: done_o is a one-cycle pulse in the cycle right after the last busy cycle. In that same cycle, res_code_o shows result_code_i as sampled at the edge that ends busy. The result outputs change only with done_o.
- R8: res_chan_o is the channel that was selected when the conversion started, even if the channel is rewritten during the conversion.
- R9: Start requests that arrive while busy_o is high are ignored and not queued.
- R10: While power-down is set, start requests are ignored and busy_o and hold_o stay low. This includes a start in the very write that sets power-down. A power-down write during a conversion ends it on that edge without a done_o pulse. A write that clears power-down with start set starts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| convst_i | input | 1 | Asynchronous convert-start pin, rising edge starts |
| ctrl_wr_i | input | 1 | One-cycle control-register write strobe |
| ctrl_chan_i | input | 3 | Channel address written |
| ctrl_start_i | input | 1 | Start bit written |
| ctrl_pd_i | input | 1 | Power-down bit written |
| settle_len_i | input | SETTLE_W | Settling pulse length in clock cycles |
| result_code_i | input | 12 | Behavioural converter code |
| chan_o | output | 3 | Currently selected channel |
| settling_o | output | 1 | Settling pulse active |
| hold_o | output | 1 | Track/hold in hold |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle end-of-conversion strobe |
| res_chan_o | output | 3 | Channel of the latest result |
| res_code_o | output | 12 | Code of the latest result |

## Verification
The bench builds the block with CONV_CYC=6, MIN_HI=3 and SETTLE_W=4. The short conversion keeps each run only a few cycles long, so many conversions fit in one test. MIN_HI=3 makes it possible to check that a two-sample pulse is rejected while a three-sample pulse starts a conversion. With a 4-bit settle length, every length from 0 to 15 can be reached, including a pulse long enough that a filtered convert-start edge lands inside it and must wait.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  parameter int CHAN_W = 3;
  parameter int CODE_W = 12;

  typedef struct packed {
    logic [CHAN_W-1:0] chan;
    logic [CODE_W-1:0] code;
  } result_t;
endpackage

// File: rtl/adc_cs_filter.sv
module adc_cs_filter #(
  parameter int MIN_HI = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fire_o
);
  localparam int CW = (MIN_HI < 1) ? 1 : $clog2(MIN_HI + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] hi_q, hi_d;

  always_comb begin
    if (!s2_q)                   hi_d = '0;
    else if (hi_q == CW'(MIN_HI)) hi_d = hi_q;
    else                          hi_d = hi_q + CW'(1);
  end

  assign fire_o = s2_q && (hi_q == CW'(MIN_HI - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      hi_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/adc_settle_timer.sv
module adc_settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         active_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = len_i;
    else        cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active_o = (cnt_q != '0);
endmodule

// File: rtl/adc_conv_engine.sv
module adc_conv_engine
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYC = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              abort_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              busy_o,
  output logic              hold_o,
  output logic              done_o,
  output result_t           res_o
);
  localparam int CW = $clog2(CONV_CYC);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic              busy_q, busy_d;
  logic              hold_q, hold_d;
  logic              done_q, done_d;
  logic [CHAN_W-1:0] cch_q, cch_d;
  result_t           res_q, res_d;
  logic              res_en;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    hold_d = hold_q;
    done_d = 1'b0;
    cch_d  = cch_q;
    res_d  = res_q;
    res_en = 1'b0;
    if (abort_i) begin
      busy_d = 1'b0;
      hold_d = 1'b0;
    end else if (!busy_q) begin
      if (launch_i) begin
        busy_d = 1'b1;
        hold_d = 1'b1;
        cnt_d  = CW'(CONV_CYC - 1);
        cch_d  = chan_i;
      end
    end else if (cnt_q == '0) begin
      busy_d     = 1'b0;
      hold_d     = 1'b0;
      done_d     = 1'b1;
      res_en     = 1'b1;
      res_d.chan = cch_q;
      res_d.code = code_i;
    end else begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      done_q <= 1'b0;
      cch_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      hold_q <= hold_d;
      done_q <= done_d;
      cch_q  <= cch_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign busy_o = busy_q;
  assign hold_o = hold_q;
  assign done_o = done_q;
  assign res_o  = res_q;
endmodule

// File: rtl/adc_start_seq.sv
module adc_start_seq
  import adc_seq_pkg::*;
#(
  parameter int CONV_CYC = 14,
  parameter int MIN_HI   = 1,
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                convst_i,
  input  logic                ctrl_wr_i,
  input  logic [CHAN_W-1:0]   ctrl_chan_i,
  input  logic                ctrl_start_i,
  input  logic                ctrl_pd_i,
  input  logic [SETTLE_W-1:0] settle_len_i,
  input  logic [CODE_W-1:0]   result_code_i,
  output logic [CHAN_W-1:0]   chan_o,
  output logic                settling_o,
  output logic                hold_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [CHAN_W-1:0]   res_chan_o,
  output logic [CODE_W-1:0]   res_code_o
);
  logic [CHAN_W-1:0] chan_q, chan_d;
  logic              pd_q, pd_d;
  logic              pend_q, pend_d;
  logic              cs_fire, settle_act, busy;
  logic              chg_now, pd_eff, req, blocked, launch;
  result_t           res;

  adc_cs_filter #(.MIN_HI(MIN_HI)) u_filt (
    .clk(clk), .rst_n(rst_n), .pin_i(convst_i), .fire_o(cs_fire)
  );

  adc_settle_timer #(.W(SETTLE_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .load_i(chg_now), .len_i(settle_len_i),
    .active_o(settle_act)
  );

  adc_conv_engine #(.CONV_CYC(CONV_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .abort_i(pd_eff),
    .chan_i(chan_q), .code_i(result_code_i), .busy_o(busy),
    .hold_o(hold_o), .done_o(done_o), .res_o(res)
  );

  always_comb begin
    chg_now = ctrl_wr_i && (ctrl_chan_i != chan_q);
    pd_eff  = ctrl_wr_i ? ctrl_pd_i : pd_q;
    req     = cs_fire || (ctrl_wr_i && ctrl_start_i);
    blocked = settle_act || chg_now;
    launch  = (req || pend_q) && !busy && !pd_eff && !blocked;

    chan_d = ctrl_wr_i ? ctrl_chan_i : chan_q;
    pd_d   = pd_eff;
    if (pd_eff || launch)          pend_d = 1'b0;
    else if (req && !busy && blocked) pend_d = 1'b1;
    else                           pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      pd_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      chan_q <= chan_d;
      pd_q   <= pd_d;
      pend_q <= pend_d;
    end
  end

  assign chan_o     = chan_q;
  assign settling_o = settle_act;
  assign busy_o     = busy;
  assign res_chan_o = res.chan;
  assign res_code_o = res.code;
endmodule

// File: rtl/adc_start_seq_chk.sv
module adc_start_seq_chk #(
  parameter int CONV_CYC = 14,
  parameter int CODE_W   = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy_o,
  input logic              hold_o,
  input logic              done_o,
  input logic              settling_o,
  input logic              pd_q,
  input logic [CODE_W-1:0] res_code_o
);
  localparam int BW = $clog2(CONV_CYC + 2);
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bcnt <= '0;
    else if (busy_o) bcnt <= bcnt + BW'(1);
    else             bcnt <= '0;
  end

  AST_HOLD_MATCH: assert property (@(posedge clk) disable iff (!rst_n) hold_o == busy_o); // R6
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> bcnt < BW'(CONV_CYC)); // R6
  AST_DONE_LEN: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> bcnt == BW'(CONV_CYC)); // R6
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> ($past(busy_o) && !busy_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R7
  AST_RES_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !done_o |-> $stable(res_code_o)); // R7
  AST_NO_START_SETTLING: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> !$past(settling_o)); // R5
  AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) pd_q |-> (!busy_o && !hold_o)); // R10
endmodule

bind adc_start_seq adc_start_seq_chk #(.CONV_CYC(CONV_CYC), .CODE_W(adc_seq_pkg::CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .hold_o(hold_o), .done_o(done_o),
  .settling_o(settling_o), .pd_q(pd_q), .res_code_o(res_code_o)
);

// File: tb/adc_start_seq_tb.sv
`timescale 1ns/1ps
module adc_start_seq_tb;
  localparam int CONV_CYC = 6;
  localparam int MIN_HI   = 3;
  localparam int SETTLE_W = 4;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                convst_i, ctrl_wr_i, ctrl_start_i, ctrl_pd_i;
  logic [2:0]          ctrl_chan_i;
  logic [SETTLE_W-1:0] settle_len_i;
  logic [11:0]         result_code_i;
  logic [2:0]          chan_o, res_chan_o;
  logic                settling_o, hold_o, busy_o, done_o;
  logic [11:0]         res_code_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cur_chan = 0;

  always #2.5 clk = ~clk;

  adc_start_seq #(.CONV_CYC(CONV_CYC), .MIN_HI(MIN_HI), .SETTLE_W(SETTLE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .convst_i(convst_i), .ctrl_wr_i(ctrl_wr_i),
    .ctrl_chan_i(ctrl_chan_i), .ctrl_start_i(ctrl_start_i), .ctrl_pd_i(ctrl_pd_i),
    .settle_len_i(settle_len_i), .result_code_i(result_code_i), .chan_o(chan_o),
    .settling_o(settling_o), .hold_o(hold_o), .busy_o(busy_o), .done_o(done_o),
    .res_chan_o(res_chan_o), .res_code_o(res_code_o)
  );

  function automatic int exp_delay(input bit changed, input int len);
    return changed ? len + 1 : 0;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wr(input int ch, input bit st, input bit pd, input int len);
    @(negedge clk);
    ctrl_wr_i    = 1'b1;
    ctrl_chan_i  = 3'(ch);
    ctrl_start_i = st;
    ctrl_pd_i    = pd;
    settle_len_i = SETTLE_W'(len);
    @(negedge clk);
    ctrl_wr_i    = 1'b0;
    ctrl_start_i = 1'b0;
  endtask

  task automatic run_conv(input int exp_d, input int exp_ch, input int exp_code, input string tag);
    int d;
    int n;
    int hold_bad;
    d = 0; n = 0; hold_bad = 0;
    while (!busy_o && d < 200) begin @(negedge clk); d++; end
    chk({tag, " start delay"}, d, exp_d);
    while (busy_o && n < 200) begin
      if (hold_o !== 1'b1) hold_bad++;
      n++;
      @(negedge clk);
    end
    chk("R6 busy length", n, CONV_CYC);
    chk("R6 hold follows busy", hold_bad, 0);
    chk("R7 done after busy", int'(done_o), 1);
    chk("R7 result code", int'(res_code_o), exp_code);
    chk("R8 result channel", int'(res_chan_o), exp_ch);
    @(negedge clk);
    chk("R7 done single cycle", int'(done_o), 0);
  endtask

  task automatic cs_pulse(input int n, output int first);
    first = -1;
    convst_i = 1'b1;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      if (i == n) convst_i = 1'b0;
      if (busy_o && first < 0) first = i;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int first, b, dn, cnt;
    void'($urandom(32'd4711));
    rst_n = 1'b0; convst_i = 0; ctrl_wr_i = 0; ctrl_start_i = 0; ctrl_pd_i = 0;
    ctrl_chan_i = 0; settle_len_i = 0; result_code_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 hold", int'(hold_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 settling", int'(settling_o), 0);
    chk("R1 result", int'({res_chan_o, res_code_o}), 0);
    chk("R1 channel", int'(chan_o), 0);

    // R3 start on unchanged channel
    result_code_i = 12'hA5C;
    wr(0, 1, 0, 0);
    run_conv(0, 0, 12'hA5C, "R3");

    // R4 settling pulse length
    wr(5, 0, 0, 9);
    cnt = 0;
    while (settling_o && cnt < 50) begin cnt++; @(negedge clk); end
    chk("R4 settling length", cnt, 9);
    chk("R4 no conversion without start", int'(busy_o), 0);
    cur_chan = 5;

    // R5 start in same write as channel change
    result_code_i = 12'h123;
    wr(2, 1, 0, 7);
    run_conv(exp_delay(1, 7), 2, 12'h123, "R5");
    result_code_i = 12'h0FE;
    wr(6, 1, 0, 0);
    run_conv(exp_delay(1, 0), 6, 12'h0FE, "R5 zero length");
    cur_chan = 6;

    // R2 filtered convert-start
    result_code_i = 12'h7C1;
    cs_pulse(MIN_HI, first);
    chk("R2 accepted pulse start", first, MIN_HI + 2);
    chk("R2 result code", int'(res_code_o), 12'h7C1);
    cs_pulse(MIN_HI - 1, first);
    chk("R2 short pulse ignored", first, -1);

    // R5 convert-start edge deferred by settling
    result_code_i = 12'h3B0;
    wr(1, 0, 0, 12);
    cs_pulse(4, first);
    chk("R5 deferred convst start", first, 13);
    chk("R5 deferred result channel", int'(res_chan_o), 1);
    cur_chan = 1;

    // R9 request while busy ignored
    result_code_i = 12'h456;
    wr(1, 1, 0, 0);
    b = int'(busy_o); dn = 0;
    repeat (2) begin @(negedge clk); b += int'(busy_o); dn += int'(done_o); end
    ctrl_wr_i = 1; ctrl_chan_i = 1; ctrl_start_i = 1; ctrl_pd_i = 0;
    @(negedge clk);
    ctrl_wr_i = 0; ctrl_start_i = 0;
    b += int'(busy_o); dn += int'(done_o);
    repeat (30) begin @(negedge clk); b += int'(busy_o); dn += int'(done_o); end
    chk("R9 busy cycles", b, CONV_CYC);
    chk("R9 done count", dn, 1);

    // R8 channel rewritten during conversion
    result_code_i = 12'h9AA;
    wr(1, 1, 0, 0);
    @(negedge clk);
    wr(4, 0, 0, 2);
    cnt = 0;
    while (!done_o && cnt < 50) begin cnt++; @(negedge clk); end
    chk("R8 result keeps start channel", int'(res_chan_o), 1);
    chk("R8 new channel selected", int'(chan_o), 4);
    repeat (5) @(negedge clk);
    cur_chan = 4;

    // R10 power-down blocks starts
    wr(4, 1, 1, 0);
    b = 0;
    repeat (30) begin @(negedge clk); b += int'(busy_o) + int'(hold_o); end
    chk("R10 start in power-down write ignored", b, 0);
    cs_pulse(4, first);
    chk("R10 convst ignored in power-down", first, -1);
    result_code_i = 12'hC0D;
    wr(4, 1, 0, 0);
    run_conv(0, 4, 12'hC0D, "R10 leave power-down");

    // R10 abort by power-down
    result_code_i = 12'h111;
    wr(4, 1, 0, 0);
    @(negedge clk);
    wr(4, 0, 1, 0);
    chk("R10 abort busy", int'(busy_o), 0);
    chk("R10 abort hold", int'(hold_o), 0);
    dn = 0;
    repeat (20) begin @(negedge clk); dn += int'(done_o); end
    chk("R10 no done after abort", dn, 0);
    chk("R10 result unchanged", int'(res_code_o), 12'hC0D);
    wr(4, 0, 0, 0);

    // R3 / R5 random mix
    for (int k = 0; k < 24; k++) begin
      int ch, len, code;
      ch = int'($urandom % 8);
      len = int'($urandom % 16);
      code = int'($urandom % 4096);
      result_code_i = 12'(code);
      wr(ch, 1, 0, len);
      run_conv(exp_delay(ch != cur_chan, len), ch, code, "R5 random");
      cur_chan = ch;
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule